// File: doc/BRIEF.md
# Panel Pixel Colour Pipeline

This block processes a stream of 8-bit-per-channel red, green and blue pixels on their way to a flat panel. Each channel goes through four steps in a fixed order. The first is a contrast gain, where 0x80 means unity. The second is a signed brightness offset that saturates. The third is an optional gamma look-up in a per-channel table. The last is an optional ordered dither that truncates the result to 8, 7 or 6 significant bits. A background-colour override and a low-bit clear can be applied on top of the processed value.

The gamma tables are loaded through a shared indirect port. One strobe loads the table index. A second strobe stores a byte at that index in every table whose write-enable bit is set, then advances the index. The dither threshold comes from a 2×2 ordered matrix, addressed by the parity of the pixel column and the parity of the line. In dynamic mode the matrix position is rotated by a 2-bit frame counter.

The per-pixel selections are captured together with the pixel and travel down the pipeline beside it. These selections are gamma enable, dither mode, the mutes and the matrix position. Gains, offsets and the background colour are treated as quasi-static settings. The block contains no finite-state machine, only a fixed four-register pipeline.

Top module: `pxl_color_pipe`

## Requirements
- R1: `out_de` equals `in_de` sampled four rising edges earlier. While `out_de` is low, `out_r`, `out_g` and `out_b` are zero. All outputs are zero during reset.
- R2: Contrast per channel is floor(pixel × gain / 128). A gain of 0x80 passes the pixel unchanged, 0x00 gives zero and 0xFF nearly doubles it.
- R3: The brightness offset is an 8-bit two's-complement value added to the contrast result. 0x80 is −128, 0x00 is neutral and 0x7F is +127. The sum is clamped to the range 0..255.
- R4: When `gam_en` is 1, the clamped value indexes the channel's 256-entry table and the table entry replaces the value. When `gam_en` is 0, the value passes unchanged.
- R5: `tbl_addr_wr` loads the table index from `tbl_wdata`. `tbl_data_wr`, when `tbl_addr_wr` is low, writes `tbl_wdata` at the index into each table whose `tbl_we` bit is set, then increments the index, wrapping from 255 to 0. In `tbl_we`, bit 0 is red, bit 1 is green and bit 2 is blue. When both strobes are high, only the index load takes effect.
- R6: For `dith_mode` 00 (off) and 01 (8-bit) the value passes unchanged. For mode 10 (7-bit) and mode 11 (6-bit), a threshold t is added, the sum is clamped to 255, and then 1 or 2 low bits respectively are cleared.
- R7: The matrix index is 2×`in_row_odd` + `in_col_odd`. Indices 0, 1, 2 and 3 map to the 2-bit thresholds 0, 2, 3 and 1. In 6-bit mode t is that threshold. In 7-bit mode t is the threshold shifted right by one.
- R8: With `dith_dyn` high, the index is (2×row + col + F) mod 4. F is a 2-bit frame count that is 0 after reset and increments on each `frame_start`. The pixel presented with `frame_start` already uses the incremented count.
- R9: When `mute_bg` is set, each channel outputs its background colour (`bg_r`, `bg_g`, `bg_b`) in place of the processed value.
- R10: When `mute_lsb` is set, bits [1:0] of every output channel are zero. This also applies on top of the background colour.
- R11: `gam_en`, `dith_mode`, `dith_dyn`, `mute_bg` and `mute_lsb` take effect from the pixel presented in the same cycle. Changing them on consecutive pixels gives each pixel its own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_de | input | 1 | Input pixel valid |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| in_col_odd | input | 1 | Pixel column parity |
| in_row_odd | input | 1 | Line parity |
| frame_start | input | 1 | Pulse with the first pixel of a frame |
| gain_r | input | 8 | Red contrast gain, 0x80 unity |
| gain_g | input | 8 | Green contrast gain |
| gain_b | input | 8 | Blue contrast gain |
| offs_r | input | 8 | Red brightness offset, signed |
| offs_g | input | 8 | Green brightness offset, signed |
| offs_b | input | 8 | Blue brightness offset, signed |
| gam_en | input | 1 | Route pixels through the gamma tables |
| tbl_we | input | 3 | Table write enables {blue, green, red} |
| tbl_addr_wr | input | 1 | Load table index strobe |
| tbl_data_wr | input | 1 | Table data write strobe |
| tbl_wdata | input | 8 | Index or data for the table port |
| dith_mode | input | 2 | Output depth: off, 8, 7, 6 bits |
| dith_dyn | input | 1 | Frame-varying dither |
| mute_bg | input | 1 | Force background colour |
| mute_lsb | input | 1 | Force output bits [1:0] low |
| bg_r | input | 8 | Background red |
| bg_g | input | 8 | Background green |
| bg_b | input | 8 | Background blue |
| out_de | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
The background override and the dither truncation can act on the same pixel. So can the low-bit clear and the background colour. Both pairs are provoked by streams that set `mute_bg` together with 6-bit dither and gamma, with and without `mute_lsb`. They are judged by expecting the background byte, with bits [1:0] cleared when `mute_lsb` is set, and no trace of threshold or table. Per-pixel toggling of `mute_bg` and `dith_mode` shows that each pixel keeps the selection it entered with. Saturation of the dither sum meets the brightness clamp in the 255 sweeps, where the expected value stays at 255 before masking.

// File: rtl/pxl_color_pkg.sv
package pxl_color_pkg;

    localparam int NUM_CH     = 3;
    localparam int LSB_MUTE_W = 2;

    typedef enum logic [1:0] {
        DITH_OFF = 2'b00,
        DITH_D8  = 2'b01,
        DITH_D7  = 2'b10,
        DITH_D6  = 2'b11
    } dith_mode_e;

    // Per-pixel selections that travel beside the pixel data.
    typedef struct packed {
        logic       de;
        logic       gam_en;
        dith_mode_e mode;
        logic       mute_bg;
        logic       mute_lsb;
        logic [1:0] thr_idx;
    } pix_ctl_t;

    // 2x2 ordered matrix: index {row,col} -> threshold (R7)
    function automatic logic [1:0] bayer2x2(input logic [1:0] idx);
        logic [1:0] t;
        case (idx)
            2'd0:    t = 2'd0;
            2'd1:    t = 2'd2;
            2'd2:    t = 2'd3;
            default: t = 2'd1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pxl_chan_arith.sv
// Two-stage contrast gain and saturating signed brightness offset.
module pxl_chan_arith #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix,
    input  logic [DW-1:0] gain,
    input  logic [DW-1:0] offs,
    output logic [DW-1:0] res
);
    localparam int PW = 2 * DW;   // product width
    localparam int CW = DW + 1;   // contrast result width
    localparam int SW = DW + 3;   // signed sum width

    logic [PW-1:0] prod;
    logic [CW-1:0] con_q;
    logic signed [SW-1:0] sum;
    logic [DW-1:0] clamp;

    assign prod = pix * gain;

    // Stage 1: gain with unity at half scale (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) con_q <= '0;
        else        con_q <= prod[PW-1:DW-1];
    end

    // Stage 2: signed offset and clamp to 0..max (R3)
    always_comb begin
        sum = $signed({2'b00, con_q}) + $signed({{3{offs[DW-1]}}, offs});
        if (sum[SW-1])                clamp = '0;
        else if (sum[SW-2:DW] != '0)  clamp = '1;
        else                          clamp = sum[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res <= '0;
        else        res <= clamp;
    end
endmodule

// File: rtl/pxl_gamma_lut.sv
// One channel's look-up table with registered read and bypass copy.
module pxl_gamma_lut #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_idx,
    input  logic          use_tbl,
    output logic [DW-1:0] res
);
    localparam int DEPTH = 1 << DW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    logic [DW-1:0] byp_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_q <= mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= '0;
        else        byp_q <= rd_idx;
    end

    // use_tbl is the selection already aligned with this stage (R4)
    assign res = use_tbl ? rd_q : byp_q;
endmodule

// File: rtl/pxl_dither_out.sv
// Ordered dither, depth truncation, mutes and output register.
module pxl_dither_out
    import pxl_color_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] val,
    input  pix_ctl_t      ctl,
    input  logic [DW-1:0] bg,
    output logic [DW-1:0] res
);
    logic [1:0]    drop;
    logic [1:0]    thr;
    logic [DW:0]   sum;
    logic [DW-1:0] sat;
    logic [DW-1:0] nxt;

    always_comb begin
        unique case (ctl.mode)
            DITH_D7: drop = 2'd1;
            DITH_D6: drop = 2'd2;
            default: drop = 2'd0;
        endcase
        // threshold scaled to the number of dropped bits (R6, R7)
        unique case (drop)
            2'd2:    thr = bayer2x2(ctl.thr_idx);
            2'd1:    thr = {1'b0, bayer2x2(ctl.thr_idx) >> 1};
            default: thr = 2'd0;
        endcase
        sum = {1'b0, val} + {{(DW-1){1'b0}}, thr};
        sat = sum[DW] ? '1 : sum[DW-1:0];
        nxt = sat & ({DW{1'b1}} << drop);
        if (ctl.mute_bg)  nxt = bg;                       // R9
        if (ctl.mute_lsb) nxt[LSB_MUTE_W-1:0] = '0;       // R10
        if (!ctl.de)      nxt = '0;                       // R1
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res <= '0;
        else        res <= nxt;
    end
endmodule

// File: rtl/pxl_color_pipe.sv
module pxl_color_pipe
    import pxl_color_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_de,
    input  logic [DW-1:0] in_r,
    input  logic [DW-1:0] in_g,
    input  logic [DW-1:0] in_b,
    input  logic          in_col_odd,
    input  logic          in_row_odd,
    input  logic          frame_start,
    input  logic [DW-1:0] gain_r,
    input  logic [DW-1:0] gain_g,
    input  logic [DW-1:0] gain_b,
    input  logic [DW-1:0] offs_r,
    input  logic [DW-1:0] offs_g,
    input  logic [DW-1:0] offs_b,
    input  logic          gam_en,
    input  logic [2:0]    tbl_we,
    input  logic          tbl_addr_wr,
    input  logic          tbl_data_wr,
    input  logic [DW-1:0] tbl_wdata,
    input  logic [1:0]    dith_mode,
    input  logic          dith_dyn,
    input  logic          mute_bg,
    input  logic          mute_lsb,
    input  logic [DW-1:0] bg_r,
    input  logic [DW-1:0] bg_g,
    input  logic [DW-1:0] bg_b,
    output logic          out_de,
    output logic [DW-1:0] out_r,
    output logic [DW-1:0] out_g,
    output logic [DW-1:0] out_b
);
    localparam int CTL_STAGES = 3;

    logic [DW-1:0] pix_a  [NUM_CH];
    logic [DW-1:0] gain_a [NUM_CH];
    logic [DW-1:0] offs_a [NUM_CH];
    logic [DW-1:0] bg_a   [NUM_CH];
    logic [DW-1:0] ari_o  [NUM_CH];
    logic [DW-1:0] lut_o  [NUM_CH];
    logic [DW-1:0] out_a  [NUM_CH];

    assign pix_a  = '{in_r, in_g, in_b};
    assign gain_a = '{gain_r, gain_g, gain_b};
    assign offs_a = '{offs_r, offs_g, offs_b};
    assign bg_a   = '{bg_r, bg_g, bg_b};

    // Frame counter; the pixel with frame_start sees the new count (R8)
    logic [1:0] fcnt_q;
    logic [1:0] fcnt_eff;
    assign fcnt_eff = frame_start ? fcnt_q + 2'd1 : fcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcnt_q <= '0;
        else        fcnt_q <= fcnt_eff;
    end

    // Per-pixel selections captured with the pixel (R11)
    pix_ctl_t ctl_in;
    pix_ctl_t ctl_q [CTL_STAGES];

    always_comb begin
        ctl_in.de       = in_de;
        ctl_in.gam_en   = gam_en;
        ctl_in.mode     = dith_mode_e'(dith_mode);
        ctl_in.mute_bg  = mute_bg;
        ctl_in.mute_lsb = mute_lsb;
        ctl_in.thr_idx  = {in_row_odd, in_col_odd} + (dith_dyn ? fcnt_eff : 2'd0);
    end

    generate
        for (genvar s = 0; s < CTL_STAGES; s++) begin : g_ctl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ctl_q[s] <= '0;
                else if (s == 0) ctl_q[s] <= ctl_in;
                else             ctl_q[s] <= ctl_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_de <= 1'b0;
        else        out_de <= ctl_q[CTL_STAGES-1].de;
    end

    // Indirect table port with auto-increment (R5)
    logic [DW-1:0] tbl_idx_q;
    logic          tbl_wr;
    assign tbl_wr = tbl_data_wr & ~tbl_addr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tbl_idx_q <= '0;
        else if (tbl_addr_wr) tbl_idx_q <= tbl_wdata;
        else if (tbl_data_wr) tbl_idx_q <= tbl_idx_q + 1'b1;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pxl_chan_arith #(.DW(DW)) u_arith (
                .clk   (clk),
                .rst_n (rst_n),
                .pix   (pix_a[c]),
                .gain  (gain_a[c]),
                .offs  (offs_a[c]),
                .res   (ari_o[c])
            );
            pxl_gamma_lut #(.DW(DW)) u_lut (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (tbl_wr & tbl_we[c]),
                .wr_addr (tbl_idx_q),
                .wr_data (tbl_wdata),
                .rd_idx  (ari_o[c]),
                .use_tbl (ctl_q[CTL_STAGES-1].gam_en),
                .res     (lut_o[c])
            );
            pxl_dither_out #(.DW(DW)) u_dith (
                .clk   (clk),
                .rst_n (rst_n),
                .val   (lut_o[c]),
                .ctl   (ctl_q[CTL_STAGES-1]),
                .bg    (bg_a[c]),
                .res   (out_a[c])
            );
        end
    endgenerate

    assign out_r = out_a[0];
    assign out_g = out_a[1];
    assign out_b = out_a[2];
endmodule

// File: rtl/pxl_color_pipe_chk.sv
module pxl_color_pipe_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_de,
    input logic [1:0]    dith_mode,
    input logic          mute_bg,
    input logic          mute_lsb,
    input logic [DW-1:0] bg_r,
    input logic          out_de,
    input logic [DW-1:0] out_r,
    input logic [DW-1:0] out_g,
    input logic [DW-1:0] out_b
);
    // cycles since reset, saturating; guards the 4-deep history
    logic [2:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
    end

    logic warm;
    assign warm = (cyc_q >= 3'd4);

    assert_de_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_de == $past(in_de, 4));

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_r == '0 && out_g == '0 && out_b == '0));

    assert_bg_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_de && $past(mute_bg, 4) && !$past(mute_lsb, 4))
        |-> out_r == $past(bg_r));

    assert_lsb_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_de && $past(mute_lsb, 4))
        |-> (out_r[1:0] == 2'b00 && out_g[1:0] == 2'b00 && out_b[1:0] == 2'b00));

    assert_depth6_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_de && !$past(mute_bg, 4) && $past(dith_mode, 4) == 2'b11)
        |-> (out_r[1:0] == 2'b00 && out_g[1:0] == 2'b00 && out_b[1:0] == 2'b00));

    assert_depth7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_de && !$past(mute_bg, 4) && $past(dith_mode, 4) == 2'b10)
        |-> (out_r[0] == 1'b0 && out_g[0] == 1'b0 && out_b[0] == 1'b0));
endmodule

bind pxl_color_pipe pxl_color_pipe_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_de     (in_de),
    .dith_mode (dith_mode),
    .mute_bg   (mute_bg),
    .mute_lsb  (mute_lsb),
    .bg_r      (bg_r),
    .out_de    (out_de),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/tb_pxl_color_pipe.sv
`timescale 1ns/1ps
module tb_pxl_color_pipe;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_de = 0, in_col_odd = 0, in_row_odd = 0, frame_start = 0;
    logic [7:0] in_r = 0, in_g = 0, in_b = 0;
    logic [7:0] gain_r = 8'h80, gain_g = 8'h80, gain_b = 8'h80;
    logic [7:0] offs_r = 0, offs_g = 0, offs_b = 0;
    logic gam_en = 0, tbl_addr_wr = 0, tbl_data_wr = 0;
    logic [2:0] tbl_we = 3'b111;
    logic [7:0] tbl_wdata = 0;
    logic [1:0] dith_mode = 0;
    logic dith_dyn = 0, mute_bg = 0, mute_lsb = 0;
    logic [7:0] bg_r = 0, bg_g = 0, bg_b = 0;
    logic out_de;
    logic [7:0] out_r, out_g, out_b;

    always #5 clk = ~clk;

    pxl_color_pipe dut (.*);

    int checks = 0, fails = 0, stepn = 0;
    logic done = 0;
    logic [7:0] m_tbl [3][256];
    logic [7:0] m_addr = 0;
    logic [1:0] m_fcnt = 0;
    logic       sl_de [4];
    logic [7:0] sl_r [4], sl_g [4], sl_b [4];
    string      sl_tag [4];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at step %0d", tag, act, exp, stepn);
        end
    endtask

    function automatic logic [7:0] mdl(input int ch, input logic [7:0] p, input logic [7:0] g,
                                       input logic [7:0] o, input logic [1:0] idx);
        int c, s, k, b, t, v;
        c = (int'(p) * int'(g)) / 128;                  // R2
        s = c + int'($signed(o));                       // R3
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        if (gam_en) s = int'(m_tbl[ch][s]);             // R4
        k = (dith_mode == 2'b11) ? 2 : (dith_mode == 2'b10) ? 1 : 0;
        case (idx)                                      // R7
            2'd0: b = 0;
            2'd1: b = 2;
            2'd2: b = 3;
            default: b = 1;
        endcase
        t = (k == 2) ? b : (k == 1) ? b / 2 : 0;
        v = s + t;
        if (v > 255) v = 255;
        v = (v >> k) << k;                              // R6
        if (mute_bg) v = (ch == 0) ? bg_r : (ch == 1) ? bg_g : bg_b;   // R9
        if (mute_lsb) v = v & 252;                      // R10
        return v[7:0];
    endfunction

    // Called at a negedge with the inputs for this cycle already driven.
    task automatic step(input string tag);
        int s;
        logic [1:0] idx;
        s = stepn % 4;
        if (frame_start) m_fcnt = m_fcnt + 2'd1;        // R8
        idx = {in_row_odd, in_col_odd};
        if (dith_dyn) idx = idx + m_fcnt;
        sl_de[s]  = in_de;
        sl_tag[s] = tag;
        sl_r[s] = in_de ? mdl(0, in_r, gain_r, offs_r, idx) : 8'h00;
        sl_g[s] = in_de ? mdl(1, in_g, gain_g, offs_g, idx) : 8'h00;
        sl_b[s] = in_de ? mdl(2, in_b, gain_b, offs_b, idx) : 8'h00;
        if (tbl_addr_wr) m_addr = tbl_wdata;            // R5
        else if (tbl_data_wr) begin
            for (int c = 0; c < 3; c++) if (tbl_we[c]) m_tbl[c][m_addr] = tbl_wdata;
            m_addr = m_addr + 8'd1;
        end
        stepn++;
        @(negedge clk);
        s = stepn % 4;
        check({sl_tag[s], " (R1 de)"}, out_de, sl_de[s]);
        check({sl_tag[s], " red"},   out_r, sl_r[s]);
        check({sl_tag[s], " green"}, out_g, sl_g[s]);
        check({sl_tag[s], " blue"},  out_b, sl_b[s]);
    endtask

    task automatic flush();
        in_de = 0; frame_start = 0; tbl_addr_wr = 0; tbl_data_wr = 0;
        for (int i = 0; i < 5; i++) step("R1");
    endtask

    task automatic pix(input int p, input string tag);
        in_de = 1;
        in_r = p[7:0]; in_g = ~p[7:0]; in_b = p[7:0] ^ 8'h5A;
        in_col_odd = p[0]; in_row_odd = p[1];
        step(tag);
    endtask

    task automatic twr(input logic is_addr, input logic [7:0] d);
        in_de = 0; tbl_addr_wr = is_addr; tbl_data_wr = ~is_addr; tbl_wdata = d;
        step("R5");
        tbl_addr_wr = 0; tbl_data_wr = 0;
    endtask

    initial begin
        logic [7:0] gl [5];
        logic [7:0] ol [5];
        gl = '{8'h80, 8'h40, 8'hFF, 8'h00, 8'hC0};
        ol = '{8'h00, 8'h80, 8'h7F, 8'h10, 8'hF0};
        for (int i = 0; i < 4; i++) begin sl_de[i] = 0; sl_r[i] = 0; sl_g[i] = 0; sl_b[i] = 0; sl_tag[i] = "R1"; end
        repeat (3) @(negedge clk);
        check("R1 reset de", out_de, 0);
        check("R1 reset red", out_r, 0);
        check("R1 reset blue", out_b, 0);
        rst_n = 1;

        // R2 / R3: gain and offset sweeps
        for (int gi = 0; gi < 5; gi++)
            for (int oi = 0; oi < 5; oi++) begin
                flush();
                gain_r = gl[gi]; gain_g = gl[gi]; gain_b = gl[gi];
                offs_r = ol[oi]; offs_g = ol[oi]; offs_b = ol[oi];
                for (int p = 0; p < 256; p++) pix(p, (oi == 0) ? "R2" : "R3");
            end
        flush();
        gain_r = 8'h80; gain_g = 8'h40; gain_b = 8'hFF;
        offs_r = 8'h00; offs_g = 8'h80; offs_b = 8'h7F;
        for (int p = 0; p < 256; p++) pix(p, "R3");
        flush();
        gain_r = 8'h80; gain_g = 8'h80; gain_b = 8'h80;
        offs_r = 0; offs_g = 0; offs_b = 0;

        // R5: table loading with enables, wrap and re-addressing
        tbl_we = 3'b011;
        twr(1, 8'h00);
        for (int i = 0; i < 256; i++) twr(0, i[7:0] ^ 8'h5A);
        tbl_we = 3'b010;
        twr(0, 8'hEE);                    // index wrapped to 0
        tbl_we = 3'b100;
        twr(1, 8'h00);
        for (int i = 0; i < 256; i++) twr(0, ~i[7:0]);
        tbl_we = 3'b001;
        twr(1, 8'h0A);
        twr(0, 8'h00);
        twr(0, 8'h11);
        in_de = 0; tbl_addr_wr = 1; tbl_data_wr = 1; tbl_wdata = 8'h20; step("R5");
        tbl_addr_wr = 0; tbl_data_wr = 0;
        twr(0, 8'h77);                    // lands at 0x20
        flush();

        // R4: gamma path
        gam_en = 1;
        for (int p = 0; p < 256; p++) pix(p, "R4");
        flush();
        gam_en = 0;
        for (int p = 0; p < 256; p++) pix(p, "R4");
        flush();

        // R6 / R7: static dither, all modes, all positions
        for (int m = 0; m < 4; m++) begin
            flush();
            dith_mode = m[1:0];
            for (int p = 0; p < 256; p++)
                for (int q = 0; q < 4; q++) begin
                    in_de = 1; in_r = p[7:0]; in_g = p[7:0] ^ 8'h0F; in_b = 8'hFF - p[7:0];
                    in_col_odd = q[0]; in_row_odd = q[1];
                    step((m < 2) ? "R6" : "R7");
                end
        end

        // R8: dynamic dither across frames
        for (int m = 2; m < 4; m++) begin
            flush();
            dith_mode = m[1:0]; dith_dyn = 1;
            for (int f = 0; f < 6; f++)
                for (int p = 0; p < 256; p++) begin
                    frame_start = (p == 0);
                    pix(p, "R8");
                    frame_start = 0;
                end
        end
        flush();
        dith_dyn = 0;

        // R9 / R10: mutes combined with gamma and 6-bit dither
        bg_r = 8'hC7; bg_g = 8'h3B; bg_b = 8'h81;
        gam_en = 1; dith_mode = 2'b11;
        mute_bg = 1;
        for (int p = 0; p < 64; p++) pix(p * 4 + 1, "R9");
        mute_bg = 0; mute_lsb = 1; dith_mode = 2'b00;
        for (int p = 0; p < 64; p++) pix(p * 4 + 3, "R10");
        mute_bg = 1; dith_mode = 2'b11;
        for (int p = 0; p < 64; p++) pix(p * 4 + 2, "R10");
        mute_bg = 0; mute_lsb = 0;

        // R11: per-pixel selections change on consecutive pixels
        for (int p = 0; p < 256; p++) begin
            mute_bg = p[0]; gam_en = p[1]; dith_mode = p[3:2]; mute_lsb = p[4];
            pix(p, "R11");
        end
        mute_bg = 0; gam_en = 0; dith_mode = 0; mute_lsb = 0;
        flush();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule